// File: doc/BRIEF.md
# I2C Master Bus-Access Arbiter

This block decides when an I2C master may take the bus. It watches the two bus lines, which it synchronises itself. A START (SDA falling while SCL is high) marks the bus busy and a STOP (SDA rising while SCL is high) marks it free. When software raises the start flag and the bus is free, the block asks the clock generator for a START. If the bus is busy, it holds the request and issues it as soon as a STOP frees the bus.

While it owns the bus, the block compares each bit it releases high with the level seen on SDA at the rising SCL edge. A mismatch means another master won arbitration. The block then stops driving SDA and posts a loss status code, chosen from the transfer phase and from the address match that a neighbouring comparator reports.

Two escape paths exist. A START from another master while this block owns the bus makes it back off silently. Setting the stop flag while the start flag is set and the bus is held busy by someone else clears the busy state without putting a STOP on the lines, and the pending START then goes out.

The controller has five states:
- `ARB_IDLE`: no request pending.
- `ARB_WAIT_FREE`: a start request is held until the bus is free.
- `ARB_LAUNCH`: a START has been requested and the block waits to see it on the lines.
- `ARB_OWNER`: the bus is ours.
- `ARB_LOST`: arbitration was lost; SDA is released.

Its transitions are:
- `IDLE→LAUNCH`: start flag set and bus free.
- `IDLE→WAIT_FREE`: start flag set and bus busy, or forced access.
- `WAIT_FREE→LAUNCH`: bus free.
- `WAIT_FREE→IDLE`: start flag dropped.
- `LAUNCH→OWNER`: START seen on the lines.
- `OWNER→LOST`: arbitration lost.
- `OWNER→WAIT_FREE` or `OWNER→IDLE`: foreign START, depending on the start flag.
- `OWNER→IDLE`: STOP seen.
- `LOST→LAUNCH`: start flag set and bus free.
- `LOST→WAIT_FREE`: forced access.
- `LOST→IDLE`: start flag clear and bus free.

Top module: `i2c_bus_arbiter`

## Requirements
- R1: `busy` goes high after a START is seen on the lines and low after a STOP, with two synchroniser stages plus one edge register and the busy register between the pins and the output.
- R2: With `sta` high and the bus free, the block pulses `start_req` for one cycle, sets `status` to 0x08 and sets `irq`.
- R3: With `sta` high while the bus is busy and not owned, no START is requested until a STOP frees the bus; then the START is issued without any other input change.
- R4: While owning the bus in an active phase (`phase` 1 = address, 2 = data, 3 = acknowledge; 0 = idle), a rising SCL edge with `sda_drive_hi` high and SDA sampled low is an arbitration loss, after which `sda_may_drive` is low.
- R5: The loss status is 0x68, 0x78 or 0xB0 when the loss happens in the address phase with `addr_match` 1 (own write address), 2 (general call) or 3 (own read address), and 0x38 in every other case.
- R6: After a loss with `sta` high, the block issues a START on its own once the bus is free, reporting 0x08.
- R7: A START from another master while owning the bus releases SDA without changing `status` and without setting `irq`.
- R8: With `sto_flag` and `sta` high while the bus is busy and not owned, `busy` clears on the next cycle, no `stop_req` is produced, and a START then follows.
- R9: `sto_flag` is set by `sto_set` and cleared by hardware after a `stop_req` pulse (when owning), after a forced access, or at once when `sta` is low and the bus is not owned.
- R10: `irq` stays high until `int_clr`; a new status event in the same cycle wins over the clear.
- R11: After reset, `status` is 0xF8, and `irq`, `busy`, `start_req`, `stop_req`, `sto_flag` and `sda_may_drive` are low.
- R12: A rising SCL edge with SDA low while `phase` is 0 (idle) is not a loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| sda_drive_hi | input | 1 | The current bit is released high by this master |
| phase | input | 2 | Transfer phase: 0 idle, 1 address, 2 data, 3 acknowledge |
| addr_match | input | 2 | Address comparator result: 0 none, 1 own write, 2 general call, 3 own read |
| sta | input | 1 | Software start flag (level) |
| sto_set | input | 1 | One-cycle pulse that sets the stop flag |
| int_clr | input | 1 | Clears the interrupt flag |
| start_req | output | 1 | One-cycle request to generate a START |
| stop_req | output | 1 | One-cycle request to generate a STOP |
| status | output | 8 | Status code |
| irq | output | 1 | Sticky interrupt flag |
| busy | output | 1 | Bus-busy indicator |
| sto_flag | output | 1 | Stop flag, cleared by hardware |
| sda_may_drive | output | 1 | This master may drive SDA |

## Verification
Several properties are checked on every cycle:
- a START request only follows a free-bus cycle and always carries status 0x08;
- START and STOP requests never coincide;
- a loss status always comes with SDA released;
- a forced access clears busy on the following cycle without a STOP request;
- `irq` stays high until cleared;
- `status` only ever holds a legal code.

Other behaviours depend on sequences of line activity, and only the bench scenarios can show them:
- the delayed START after a foreign STOP;
- the automatic retry after a loss;
- the silent back-off on a foreign START;
- the mapping from phase and address match to each loss code;
- the absence of any loss check in the idle phase.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_WAIT_FREE,
        ARB_LAUNCH,
        ARB_OWNER,
        ARB_LOST
    } arb_state_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_ACK  = 2'd3
    } xfer_phase_t;

    typedef enum logic [1:0] {
        AM_NONE  = 2'd0,
        AM_OWN_W = 2'd1,
        AM_GCALL = 2'd2,
        AM_OWN_R = 2'd3
    } addr_match_t;

    localparam int STATUS_W = 8;

    localparam logic [STATUS_W-1:0] ST_NO_INFO    = 8'hF8;
    localparam logic [STATUS_W-1:0] ST_START_SENT = 8'h08;
    localparam logic [STATUS_W-1:0] ST_LOST_XFER  = 8'h38;
    localparam logic [STATUS_W-1:0] ST_LOST_OWN_W = 8'h68;
    localparam logic [STATUS_W-1:0] ST_LOST_GCALL = 8'h78;
    localparam logic [STATUS_W-1:0] ST_LOST_OWN_R = 8'hB0;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor
    import i2c_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_raw,
    input  logic scl_raw,
    input  logic force_free,
    output logic sda_s,
    output logic scl_rise,
    output logic start_det,
    output logic stop_det,
    output logic busy
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sda_sync;
    logic [SYNC_STAGES-1:0] scl_sync;
    logic                   sda_prev;
    logic                   scl_prev;
    logic                   scl_s;

    // Synchroniser chain plus one edge-reference register; lines idle high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_sync <= '1;
            scl_sync <= '1;
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_sync[0] <= sda_raw;
            scl_sync[0] <= scl_raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sda_sync[i] <= sda_sync[i-1];
                scl_sync[i] <= scl_sync[i-1];
            end
            sda_prev <= sda_sync[LAST];
            scl_prev <= scl_sync[LAST];
        end
    end

    assign sda_s     = sda_sync[LAST];
    assign scl_s     = scl_sync[LAST];
    assign scl_rise  = scl_s & ~scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (force_free) begin
            busy <= 1'b0;
        end else if (start_det) begin
            busy <= 1'b1;
        end else if (stop_det) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_arb_lost_det.sv
module i2c_arb_lost_det
    import i2c_arb_pkg::*;
#(
    parameter bit CHECK_ACK_BIT = 1'b1
) (
    input  logic                owner,
    input  logic                scl_rise,
    input  logic                sda_s,
    input  logic                drive_hi,
    input  xfer_phase_t         phase,
    input  addr_match_t         match,
    output logic                lost,
    output logic [STATUS_W-1:0] lost_code
);

    logic phase_checked;

    generate
        if (CHECK_ACK_BIT) begin : g_with_ack
            assign phase_checked = (phase != PH_IDLE);
        end else begin : g_no_ack
            assign phase_checked = (phase == PH_ADDR) || (phase == PH_DATA);
        end
    endgenerate

    // A released-high bit seen low on the SCL rising edge means another master won.
    assign lost = owner & scl_rise & drive_hi & ~sda_s & phase_checked;

    always_comb begin
        lost_code = ST_LOST_XFER;
        if (phase == PH_ADDR) begin
            unique case (match)
                AM_OWN_W: lost_code = ST_LOST_OWN_W;
                AM_GCALL: lost_code = ST_LOST_GCALL;
                AM_OWN_R: lost_code = ST_LOST_OWN_R;
                AM_NONE:  lost_code = ST_LOST_XFER;
            endcase
        end
    end

endmodule

// File: rtl/i2c_arb_fsm.sv
module i2c_arb_fsm
    import i2c_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                lost,
    input  logic [STATUS_W-1:0] lost_code,
    input  logic                sta,
    input  logic                sto_set,
    input  logic                int_clr,
    output arb_state_t          state,
    output logic                force_free,
    output logic                start_req,
    output logic                stop_req,
    output logic [STATUS_W-1:0] status,
    output logic                irq,
    output logic                sto_flag
);

    arb_state_t state_n;
    logic       not_owner;
    logic       forced;
    logic       ev_launch;
    logic       ev_lost;
    logic       ev_stop;
    logic       ev_drop;

    assign not_owner = (state == ARB_IDLE) || (state == ARB_WAIT_FREE) || (state == ARB_LOST);
    assign forced    = sto_flag & sta & busy & not_owner;
    assign ev_drop   = sto_flag & ~sta & not_owner;
    assign force_free = forced;

    always_comb begin
        state_n   = state;
        ev_launch = 1'b0;
        ev_lost   = 1'b0;
        ev_stop   = 1'b0;
        unique case (state)
            ARB_IDLE: begin
                if (forced) begin
                    state_n = ARB_WAIT_FREE;
                end else if (sta && !busy) begin
                    state_n   = ARB_LAUNCH;
                    ev_launch = 1'b1;
                end else if (sta) begin
                    state_n = ARB_WAIT_FREE;
                end
            end
            ARB_WAIT_FREE: begin
                if (forced) begin
                    state_n = ARB_WAIT_FREE;
                end else if (!sta) begin
                    state_n = ARB_IDLE;
                end else if (!busy) begin
                    state_n   = ARB_LAUNCH;
                    ev_launch = 1'b1;
                end
            end
            ARB_LAUNCH: begin
                if (start_det) begin
                    state_n = ARB_OWNER;
                end
            end
            ARB_OWNER: begin
                if (lost) begin
                    state_n = ARB_LOST;
                    ev_lost = 1'b1;
                end else if (start_det) begin
                    state_n = sta ? ARB_WAIT_FREE : ARB_IDLE;
                end else if (stop_det) begin
                    state_n = ARB_IDLE;
                end else if (sto_flag) begin
                    ev_stop = 1'b1;
                end
            end
            ARB_LOST: begin
                if (forced) begin
                    state_n = ARB_WAIT_FREE;
                end else if (sta && !busy) begin
                    state_n   = ARB_LAUNCH;
                    ev_launch = 1'b1;
                end else if (!sta && !busy) begin
                    state_n = ARB_IDLE;
                end
            end
            default: state_n = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_req <= 1'b0;
            stop_req  <= 1'b0;
            status    <= ST_NO_INFO;
            irq       <= 1'b0;
            sto_flag  <= 1'b0;
        end else begin
            start_req <= ev_launch;
            stop_req  <= ev_stop;
            if (ev_launch) begin
                status <= ST_START_SENT;
            end else if (ev_lost) begin
                status <= lost_code;
            end
            if (ev_launch || ev_lost) begin
                irq <= 1'b1;
            end else if (int_clr) begin
                irq <= 1'b0;
            end
            if (sto_set) begin
                sto_flag <= 1'b1;
            end else if (forced || ev_stop || ev_drop) begin
                sto_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_arbiter.sv
module i2c_bus_arbiter
    import i2c_arb_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter bit CHECK_ACK_BIT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_in,
    input  logic       scl_in,
    input  logic       sda_drive_hi,
    input  logic [1:0] phase,
    input  logic [1:0] addr_match,
    input  logic       sta,
    input  logic       sto_set,
    input  logic       int_clr,
    output logic       start_req,
    output logic       stop_req,
    output logic [7:0] status,
    output logic       irq,
    output logic       busy,
    output logic       sto_flag,
    output logic       sda_may_drive
);

    arb_state_t          state;
    logic                sda_s;
    logic                scl_rise;
    logic                start_det;
    logic                stop_det;
    logic                force_free;
    logic                lost;
    logic [STATUS_W-1:0] lost_code;

    i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_raw    (sda_in),
        .scl_raw    (scl_in),
        .force_free (force_free),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .busy       (busy)
    );

    i2c_arb_lost_det #(.CHECK_ACK_BIT(CHECK_ACK_BIT)) u_lost (
        .owner     (state == ARB_OWNER),
        .scl_rise  (scl_rise),
        .sda_s     (sda_s),
        .drive_hi  (sda_drive_hi),
        .phase     (xfer_phase_t'(phase)),
        .match     (addr_match_t'(addr_match)),
        .lost      (lost),
        .lost_code (lost_code)
    );

    i2c_arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .lost       (lost),
        .lost_code  (lost_code),
        .sta        (sta),
        .sto_set    (sto_set),
        .int_clr    (int_clr),
        .state      (state),
        .force_free (force_free),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .status     (status),
        .irq        (irq),
        .sto_flag   (sto_flag)
    );

    assign sda_may_drive = (state == ARB_LAUNCH) || (state == ARB_OWNER);

endmodule

// File: rtl/i2c_bus_arbiter_chk.sv
module i2c_bus_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sta,
    input logic       sto_flag,
    input logic       int_clr,
    input logic       start_req,
    input logic       stop_req,
    input logic [7:0] status,
    input logic       irq,
    input logic       busy,
    input logic       sda_may_drive
);

    logic loss_code;
    assign loss_code = (status == 8'h38) || (status == 8'h68) ||
                       (status == 8'h78) || (status == 8'hB0);

    // R2
    start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> !$past(busy));

    // R2
    start_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> (status == 8'h08));

    // R5
    legal_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loss_code || (status == 8'h08) || (status == 8'hF8));

    // R4
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loss_code |-> !sda_may_drive);

    // R8
    forced_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_flag && sta && busy && !sda_may_drive) |=> (!busy && !stop_req));

    // R9
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_req, stop_req}));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !int_clr) |=> irq);

endmodule

bind i2c_bus_arbiter i2c_bus_arbiter_chk u_chk (.*);

// File: tb/tb_i2c_bus_arbiter.sv
module tb_i2c_bus_arbiter;

    localparam int M_IDLE = 0, M_WAIT = 1, M_LAUNCH = 2, M_OWN = 3, M_LOST = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sda_line = 1'b1, scl_line = 1'b1;
    logic       drive_hi = 1'b0;
    logic [1:0] phase = 2'd0, match = 2'd0;
    logic       sta = 1'b0, sto_set = 1'b0, int_clr = 1'b0;
    logic       start_req, stop_req, irq, busy, sto_flag, sda_may_drive;
    logic [7:0] status;

    int tests = 0, fails = 0, nstarts = 0, nstops = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_bus_arbiter dut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_line), .scl_in(scl_line),
        .sda_drive_hi(drive_hi), .phase(phase), .addr_match(match),
        .sta(sta), .sto_set(sto_set), .int_clr(int_clr),
        .start_req(start_req), .stop_req(stop_req), .status(status), .irq(irq),
        .busy(busy), .sto_flag(sto_flag), .sda_may_drive(sda_may_drive)
    );

    // Behavioural reference: line history kept in queues, newest first.
    bit   sdah[$], sclh[$];
    int   ms;
    bit   mbusy, mstart, mstop, mirq, msto;
    logic [7:0] mstatus, mcode;
    bit   s2, q, c2, cq, st, sp, rise, lostv, forced, drop, ev_l, ev_x, ev_s;
    int   nxt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdah = '{1, 1, 1}; sclh = '{1, 1, 1};
            ms = M_IDLE; mbusy = 0; mstart = 0; mstop = 0; mirq = 0; msto = 0;
            mstatus = 8'hF8;
        end else begin
            s2 = sdah[1]; q = sdah[2]; c2 = sclh[1]; cq = sclh[2];
            st = c2 && cq && q && !s2;
            sp = c2 && cq && !q && s2;
            rise = c2 && !cq;
            lostv = (ms == M_OWN) && rise && drive_hi && !s2 && (phase != 2'd0);
            if (phase == 2'd1 && match == 2'd1)      mcode = 8'h68;
            else if (phase == 2'd1 && match == 2'd2) mcode = 8'h78;
            else if (phase == 2'd1 && match == 2'd3) mcode = 8'hB0;
            else                                     mcode = 8'h38;
            forced = msto && sta && mbusy && (ms == M_IDLE || ms == M_WAIT || ms == M_LOST);
            drop = msto && !sta && (ms == M_IDLE || ms == M_WAIT || ms == M_LOST);
            ev_l = 0; ev_x = 0; ev_s = 0; nxt = ms;
            case (ms)
                M_IDLE: if (forced) nxt = M_WAIT;
                        else if (sta && !mbusy) begin nxt = M_LAUNCH; ev_l = 1; end
                        else if (sta) nxt = M_WAIT;
                M_WAIT: if (forced) nxt = M_WAIT;
                        else if (!sta) nxt = M_IDLE;
                        else if (!mbusy) begin nxt = M_LAUNCH; ev_l = 1; end
                M_LAUNCH: if (st) nxt = M_OWN;
                M_OWN:  if (lostv) begin nxt = M_LOST; ev_x = 1; end
                        else if (st) nxt = sta ? M_WAIT : M_IDLE;
                        else if (sp) nxt = M_IDLE;
                        else if (msto) ev_s = 1;
                default: if (forced) nxt = M_WAIT;
                        else if (sta && !mbusy) begin nxt = M_LAUNCH; ev_l = 1; end
                        else if (!sta && !mbusy) nxt = M_IDLE;
            endcase
            if (forced) mbusy = 0; else if (st) mbusy = 1; else if (sp) mbusy = 0;
            mstart = ev_l; mstop = ev_s;
            if (ev_l) mstatus = 8'h08; else if (ev_x) mstatus = mcode;
            if (ev_l || ev_x) mirq = 1; else if (int_clr) mirq = 0;
            if (sto_set) msto = 1; else if (forced || ev_s || drop) msto = 0;
            ms = nxt;
            sdah.push_front(sda_line); void'(sdah.pop_back());
            sclh.push_front(scl_line); void'(sclh.pop_back());
        end
    end

    function automatic void chk(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk("R1", "model busy", busy, mbusy);
            chk("R2", "model start_req", start_req, mstart);
            chk("R5", "model status", status, mstatus);
            chk("R10", "model irq", irq, mirq);
            chk("R4", "model sda_may_drive", sda_may_drive, (ms == M_LAUNCH || ms == M_OWN));
            chk("R9", "model stop_req", stop_req, mstop);
            chk("R9", "model sto_flag", sto_flag, msto);
            if (start_req) nstarts++;
            if (stop_req) nstops++;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(bit d, bit c, int n);
        sda_line = d; scl_line = c; step(n);
    endtask

    task automatic line_start;
        lines(1, 0, 2); lines(1, 1, 3); lines(0, 1, 5); lines(0, 0, 3);
    endtask

    task automatic line_stop;
        lines(0, 0, 2); lines(0, 1, 3); lines(1, 1, 6);
    endtask

    task automatic pulse_sto;
        sto_set = 1; step(1); sto_set = 0;
    endtask

    task automatic pulse_clr;
        int_clr = 1; step(1); int_clr = 0;
    endtask

    task automatic expect_start(string tag, int base);
        for (int i = 0; i < 12 && nstarts == base; i++) step(1);
        chk(tag, "start_req pulses", nstarts - base, 1);
    endtask

    task automatic own_bus(string tag);
        int base = nstarts;
        sta = 1;
        expect_start(tag, base);
        line_start;
        sta = 0; step(2);
        chk(tag, "sda_may_drive when owning", sda_may_drive, 1);
    endtask

    task automatic lose(bit [1:0] ph, bit [1:0] am, logic [7:0] code, string tag);
        phase = ph; match = am; drive_hi = 1;
        lines(0, 0, 2); lines(0, 1, 5);
        drive_hi = 0; phase = 0; match = 0;
        chk(tag, "loss status", status, code);
        chk("R4", "sda released after loss", sda_may_drive, 0);
        chk("R10", "irq after loss", irq, 1);
    endtask

    initial begin
        int bs, bp;
        rst_n = 0;
        step(3);
        // R11 reset state
        chk("R11", "status", status, 8'hF8);
        chk("R11", "irq", irq, 0);
        chk("R11", "busy", busy, 0);
        chk("R11", "start/stop/sto/drive", {start_req, stop_req, sto_flag, sda_may_drive}, 0);
        rst_n = 1; step(2);

        // R1 foreign START then STOP
        line_start;
        chk("R1", "busy after START", busy, 1);
        line_stop;
        chk("R1", "busy after STOP", busy, 0);

        // R2 launch on free bus, R10 clear
        own_bus("R2");
        chk("R2", "status after launch", status, 8'h08);
        chk("R2", "irq after launch", irq, 1);
        pulse_clr; step(3);
        chk("R10", "irq after clear", irq, 0);

        // R4/R5 loss in data phase, then the other codes in the address phase
        lose(2'd2, 2'd3, 8'h38, "R5");
        line_stop;
        own_bus("R2"); lose(2'd1, 2'd1, 8'h68, "R5"); line_stop;
        own_bus("R2"); lose(2'd1, 2'd2, 8'h78, "R5"); line_stop;
        own_bus("R2"); lose(2'd1, 2'd3, 8'hB0, "R5"); line_stop;
        own_bus("R2"); lose(2'd3, 2'd0, 8'h38, "R5"); line_stop;

        // R6 automatic retry after loss
        own_bus("R2");
        sta = 1;
        lose(2'd2, 2'd0, 8'h38, "R6");
        bs = nstarts;
        step(4);
        chk("R6", "no start while busy", nstarts - bs, 0);
        line_stop;
        expect_start("R6", bs);
        chk("R6", "status after retry", status, 8'h08);
        line_start; sta = 0; step(2);

        // R12 no loss check in idle phase
        drive_hi = 1; lines(0, 0, 2); lines(0, 1, 5); drive_hi = 0;
        chk("R12", "status unchanged", status, 8'h08);
        chk("R12", "still driving", sda_may_drive, 1);
        lines(0, 0, 2);

        // R9 STOP by owner clears sto_flag
        bp = nstops;
        pulse_sto; step(3);
        chk("R9", "stop_req pulses", nstops - bp, 1);
        chk("R9", "sto_flag cleared", sto_flag, 0);
        line_stop;
        chk("R1", "busy after own STOP", busy, 0);

        // R7 foreign repeated START, then R3 delayed START
        own_bus("R2");
        pulse_clr;
        sta = 1;
        line_start;
        chk("R7", "irq stays low", irq, 0);
        chk("R7", "status unchanged", status, 8'h08);
        chk("R7", "SDA released", sda_may_drive, 0);
        chk("R3", "busy held", busy, 1);
        bs = nstarts;
        line_stop;
        expect_start("R3", bs);
        line_start; sta = 0; step(2);
        pulse_sto; step(2); line_stop;

        // R8 forced access
        line_start;
        sta = 1; step(3);
        chk("R3", "no start while foreign busy", sda_may_drive, 0);
        bs = nstarts; bp = nstops;
        pulse_sto; step(4);
        chk("R8", "busy cleared", busy, 0);
        chk("R8", "no stop_req", nstops - bp, 0);
        chk("R8", "start after force", nstarts - bs, 1);
        chk("R9", "sto_flag cleared by force", sto_flag, 0);
        line_start; sta = 0; step(2);
        pulse_sto; step(2); line_stop;

        // R9 sto without sta when not owner is dropped
        bp = nstops;
        pulse_sto; step(3);
        chk("R9", "dropped sto_flag", sto_flag, 0);
        chk("R9", "no stop_req on drop", nstops - bp, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule